// File: doc/BRIEF.md
# ATM PVC Header Translation Router

This block sits in the cell path between a single uplink PHY and up to sixteen baseboard PHYs. It steers cells along permanent virtual circuits and rewrites their headers. Cells enter as a stream of 16-bit words. The first word of each cell carries a start marker, and every word carries a direction flag and a PHY tag. The block holds two translation tables, which software fills through a simple write port: one table for cells heading down to the baseboard and one for cells heading up to the uplink.

A downstream cell is looked up by its VPI and VCI alone. The entry it hits supplies a new VPI/VCI and names the baseboard PHY that receives the cell. An upstream cell is looked up by its source PHY together with its VPI and VCI. Only the VPI/VCI are replaced, and the cell always goes to the uplink, which is tagged as PHY 0. The lookup completes when the second header word arrives. The header is rewritten on the fly, and every word leaves a fixed two cycles after it enters, so back-to-back cells never stall. A cell that hits no enabled entry is dropped whole, and a saturating counter records it.

The words of one cell must arrive on consecutive cycles. Gaps are allowed only between cells, and a cell is at least two words long.

Top module: `pvc_xlate`

## Requirements
- R1: A downstream cell (in_up=0) whose VPI and VCI equal those of an enabled downstream entry leaves with the entry's new VPI/VCI, out_up=0, and out_phy set to the entry's PHY. The cell's own in_phy plays no part in the match.
- R2: An upstream cell (in_up=1) matches only an enabled upstream entry whose PHY, VPI and VCI all equal the cell's. It leaves with the entry's new VPI/VCI, out_up=1 and out_phy=0. The same VPI/VCI arriving from a different PHY does not match.
- R3: Header layout. Word 0 holds GFC in bits 15:12, VPI in bits 11:4 and VCI bits 15:12 in bits 3:0. Word 1 holds VCI bits 11:0 in bits 15:4, PT in bits 3:1 and CLP in bit 0. GFC, PT, CLP and every word after the header pass through unchanged.
- R4: Every forwarded word appears on the output exactly two clock cycles after it is presented, in order, and out_sop marks word 0. Cells presented back to back leave back to back.
- R5: A cell that hits no enabled entry produces no output word at all, and miss_count increments by one.
- R6: miss_count is CNT_W bits wide and holds at its all-ones value once it gets there.
- R7: A cell whose VPI exceeds VPI_MAX (default 32) or whose VCI exceeds VCI_MAX (default 255) never matches, even when an entry holds exactly that key.
- R8: When several enabled entries of a table match, the one at the lowest index wins.
- R9: The two tables are independent. A downstream entry never matches an upstream cell, and an upstream entry never matches a downstream cell.
- R10: A table write replaces the whole entry in one cycle. A write made in the same cycle as a cell's lookup (the cycle its word 1 is presented) does not affect that cell, and applies to the next one.
- R11: After reset, out_valid is low, miss_count is zero and every table entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is word 0 of a cell |
| in_up | input | 1 | 1 = upstream cell, 0 = downstream cell |
| in_phy | input | PHY_W | Source PHY of the cell |
| in_data | input | 16 | Input cell word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is word 0 of a cell |
| out_up | output | 1 | Direction of the output cell |
| out_phy | output | PHY_W | Destination PHY (0 for the uplink) |
| out_data | output | 16 | Output cell word with rewritten header |
| cfg_we | input | 1 | Table write strobe |
| cfg_up | input | 1 | Selects the upstream (1) or downstream (0) table |
| cfg_addr | input | ADDR_W | Entry index |
| cfg_en | input | 1 | Entry enable |
| cfg_phy | input | PHY_W | Match PHY (upstream) or destination PHY (downstream) |
| cfg_vpi | input | 8 | Match VPI |
| cfg_vci | input | 16 | Match VCI |
| cfg_nvpi | input | 8 | Replacement VPI |
| cfg_nvci | input | 16 | Replacement VCI |
| miss_count | output | CNT_W | Saturating count of dropped cells |

## Verification
A software table write and a cell lookup can land on the same clock edge. The bench provokes this by driving a write to the entry a cell is about to hit in the very cycle that cell's second header word is presented. It then expects the old translation on that cell and the new translation on the cell that follows. A scoreboard checks every output word for content, destination tag and the exact cycle it appears, across back-to-back cells that mix hits and drops.

// File: rtl/pvc_xlate.sv
module pvc_xlate #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = $clog2(ENTRIES),
  parameter int PHY_W   = 4,
  parameter int VPI_MAX = 32,
  parameter int VCI_MAX = 255,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_up,
  input  logic [PHY_W-1:0] in_phy,
  input  logic [15:0]      in_data,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_up,
  output logic [PHY_W-1:0] out_phy,
  output logic [15:0]      out_data,
  input  logic             cfg_we,
  input  logic             cfg_up,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic             cfg_en,
  input  logic [PHY_W-1:0] cfg_phy,
  input  logic [7:0]       cfg_vpi,
  input  logic [15:0]      cfg_vci,
  input  logic [7:0]       cfg_nvpi,
  input  logic [15:0]      cfg_nvci,
  output logic [CNT_W-1:0] miss_count
);

  logic [ENTRIES-1:0] dn_en, up_en;
  logic [PHY_W-1:0]   dn_phy [ENTRIES];
  logic [PHY_W-1:0]   up_phy [ENTRIES];
  logic [7:0]         dn_vpi [ENTRIES];
  logic [7:0]         up_vpi [ENTRIES];
  logic [15:0]        dn_vci [ENTRIES];
  logic [15:0]        up_vci [ENTRIES];
  logic [7:0]         dn_nvpi [ENTRIES];
  logic [7:0]         up_nvpi [ENTRIES];
  logic [15:0]        dn_nvci [ENTRIES];
  logic [15:0]        up_nvci [ENTRIES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dn_en <= '0;
      up_en <= '0;
    end else if (cfg_we) begin
      if (cfg_up) up_en[cfg_addr] <= cfg_en;
      else        dn_en[cfg_addr] <= cfg_en;
    end

  always_ff @(posedge clk)
    if (cfg_we) begin
      if (cfg_up) begin
        up_phy[cfg_addr]  <= cfg_phy;
        up_vpi[cfg_addr]  <= cfg_vpi;
        up_vci[cfg_addr]  <= cfg_vci;
        up_nvpi[cfg_addr] <= cfg_nvpi;
        up_nvci[cfg_addr] <= cfg_nvci;
      end else begin
        dn_phy[cfg_addr]  <= cfg_phy;
        dn_vpi[cfg_addr]  <= cfg_vpi;
        dn_vci[cfg_addr]  <= cfg_vci;
        dn_nvpi[cfg_addr] <= cfg_nvpi;
        dn_nvci[cfg_addr] <= cfg_nvci;
      end
    end

  // stage 1 holds the previous word; lookup when it is word 0 and word 1 is at the input
  logic             s1_v, s1_sop, s1_up, s1_w1;
  logic [PHY_W-1:0] s1_phy;
  logic [15:0]      s1_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_sop <= 1'b0;
      s1_w1  <= 1'b0;
    end else begin
      s1_v   <= in_valid;
      s1_sop <= in_valid & in_sop;
      s1_w1  <= s1_v & s1_sop;
    end

  always_ff @(posedge clk) begin
    s1_up  <= in_up;
    s1_phy <= in_phy;
    s1_d   <= in_data;
  end

  wire        look     = s1_v & s1_sop;
  wire [7:0]  key_vpi  = s1_d[11:4];
  wire [15:0] key_vci  = {s1_d[3:0], in_data[15:4]};
  wire        in_range = (key_vpi <= 8'(VPI_MAX)) && (key_vci <= 16'(VCI_MAX));

  logic [ENTRIES-1:0] dn_m, up_m;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign dn_m[i] = dn_en[i] && dn_vpi[i] == key_vpi && dn_vci[i] == key_vci;
    assign up_m[i] = up_en[i] && up_phy[i] == s1_phy &&
                     up_vpi[i] == key_vpi && up_vci[i] == key_vci;
  end

  logic [ADDR_W-1:0] dn_sel, up_sel;
  always_comb begin
    dn_sel = '0;
    up_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dn_m[i]) dn_sel = ADDR_W'(i);
      if (up_m[i]) up_sel = ADDR_W'(i);
    end
  end

  wire             hit  = in_range & (s1_up ? |up_m : |dn_m);
  wire [7:0]       nvpi = s1_up ? up_nvpi[up_sel] : dn_nvpi[dn_sel];
  wire [15:0]      nvci = s1_up ? up_nvci[up_sel] : dn_nvci[dn_sel];
  wire [PHY_W-1:0] dst  = s1_up ? '0 : dn_phy[dn_sel];

  logic             cur_hit;
  logic [PHY_W-1:0] cur_phy;
  logic [11:0]      cur_vci_lo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur_hit    <= 1'b0;
      cur_phy    <= '0;
      cur_vci_lo <= '0;
      miss_count <= '0;
    end else if (look) begin
      cur_hit    <= hit;
      cur_phy    <= dst;
      cur_vci_lo <= nvci[11:0];
      if (!hit && miss_count != '1) miss_count <= miss_count + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_up    <= 1'b0;
      out_phy   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_v & (look ? hit : cur_hit);
      out_sop   <= look & hit;
      out_up    <= s1_up;
      out_phy   <= look ? dst : cur_phy;
      if (look)       out_data <= {s1_d[15:12], nvpi, nvci[15:12]};
      else if (s1_w1) out_data <= {cur_vci_lo, s1_d[3:0]};
      else            out_data <= s1_d;
    end

endmodule

// File: rtl/pvc_xlate_chk.sv
module pvc_xlate_chk #(
  parameter int PHY_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [15:0]      in_data,
  input logic             out_valid,
  input logic             out_sop,
  input logic             out_up,
  input logic [PHY_W-1:0] out_phy,
  input logic [15:0]      out_data,
  input logic [CNT_W-1:0] miss_count
);

  AST_UPLINK_TAG: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_up |-> out_phy == '0); // R2
  AST_GFC_KEPT: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_sop |-> out_data[15:12] == $past(in_data[15:12], 2)); // R3
  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid, 2)); // R4
  AST_HDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_sop |=> out_valid && !out_sop); // R4
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n) miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1); // R5
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) miss_count == '1 |=> miss_count == '1); // R6

endmodule

bind pvc_xlate pvc_xlate_chk #(.PHY_W(PHY_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_sop(out_sop), .out_up(out_up), .out_phy(out_phy),
  .out_data(out_data), .miss_count(miss_count)
);

// File: tb/pvc_xlate_test.sv
module pvc_xlate_test;
  localparam int CW = 4;
  localparam int NW = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 0, in_sop = 0, in_up = 0;
  logic [3:0] in_phy = 0;
  logic [15:0] in_data = 0;
  logic out_valid, out_sop, out_up;
  logic [3:0] out_phy;
  logic [15:0] out_data;
  logic cfg_we = 0, cfg_up = 0, cfg_en = 0;
  logic [3:0] cfg_addr = 0, cfg_phy = 0;
  logic [7:0] cfg_vpi = 0, cfg_nvpi = 0;
  logic [15:0] cfg_vci = 0, cfg_nvci = 0;
  logic [CW-1:0] miss_count;

  pvc_xlate #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_up(in_up),
    .in_phy(in_phy), .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop),
    .out_up(out_up), .out_phy(out_phy), .out_data(out_data), .cfg_we(cfg_we),
    .cfg_up(cfg_up), .cfg_addr(cfg_addr), .cfg_en(cfg_en), .cfg_phy(cfg_phy),
    .cfg_vpi(cfg_vpi), .cfg_vci(cfg_vci), .cfg_nvpi(cfg_nvpi), .cfg_nvci(cfg_nvci),
    .miss_count(miss_count)
  );

  typedef struct packed {
    logic [15:0] d;
    logic sop;
    logic up;
    logic [3:0] phy;
    logic [31:0] cyc;
    logic [7:0] req;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0, cyc = 0, exp_miss = 0;
  logic [15:0] seq = 16'h1000;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && out_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R5 unexpected word act=%h exp=none", out_data);
      end else begin
        item_t it;
        it = q.pop_front();
        if ({out_sop, out_up, out_phy, out_data} !== {it.sop, it.up, it.phy, it.d} || cyc != int'(it.cyc)) begin
          bad++;
          $display("FAIL R%0d act=%b/%b/%h/%h@%0d exp=%b/%b/%h/%h@%0d", it.req,
                   out_sop, out_up, out_phy, out_data, cyc, it.sop, it.up, it.phy, it.d, it.cyc);
        end
      end
    end

  task automatic wr(input logic up, input logic [3:0] a, input logic en, input logic [3:0] p,
                    input logic [7:0] vpi, input logic [15:0] vci, input logic [7:0] nvpi,
                    input logic [15:0] nvci);
    cfg_we = 1; cfg_up = up; cfg_addr = a; cfg_en = en; cfg_phy = p;
    cfg_vpi = vpi; cfg_vci = vci; cfg_nvpi = nvpi; cfg_nvci = nvci;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic up, input logic [3:0] p, input logic [7:0] vpi,
                      input logic [15:0] vci, input logic hit, input logic [7:0] evpi,
                      input logic [15:0] evci, input logic [3:0] ephy, input logic [7:0] req);
    logic [3:0] gfc = seq[3:0];
    logic [2:0] pt = seq[6:4];
    logic clp = seq[0];
    for (int w = 0; w < NW; w++) begin
      logic [15:0] d, e;
      item_t it;
      if (w == 0) begin d = {gfc, vpi, vci[15:12]}; e = {gfc, evpi, evci[15:12]}; end
      else if (w == 1) begin d = {vci[11:0], pt, clp}; e = {evci[11:0], pt, clp}; end
      else begin d = seq; e = seq; seq = seq + 16'h0101; end
      in_valid = 1; in_sop = (w == 0); in_up = up; in_phy = p; in_data = d;
      if (hit) begin
        it.d = e; it.sop = (w == 0); it.up = up; it.phy = up ? 4'd0 : ephy;
        it.cyc = 32'(cyc + 2); it.req = req;
        q.push_back(it);
      end
      @(negedge clk);
    end
    seq = seq + 16'h0013;
    if (!hit && exp_miss < (1 << CW) - 1) exp_miss++;
  endtask

  task automatic idle(input int n);
    in_valid = 0; in_sop = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_miss(input string tag);
    total++;
    if (miss_count !== CW'(exp_miss)) begin
      bad++;
      $display("FAIL %s miss_count act=%0d exp=%0d", tag, miss_count, exp_miss);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    total++;
    if (out_valid !== 1'b0 || miss_count !== '0) begin
      bad++;
      $display("FAIL R11 act=%b/%0d exp=0/0", out_valid, miss_count);
    end
    rst_n = 1;
    @(negedge clk);
    // R11 no entry enabled after reset, R5 drop
    send(0, 0, 8'd5, 16'd7, 0, 0, 0, 0, 11);
    idle(4); chk_miss("R5");
    // R1 downstream hit, R3 pass-through
    wr(0, 0, 1, 4'd3, 8'd5, 16'd7, 8'd9, 16'd300);
    send(0, 4'd9, 8'd5, 16'd7, 1, 8'd9, 16'd300, 4'd3, 1);
    idle(2);
    // R2 upstream hit and wrong-PHY miss, R9 separate tables
    wr(1, 2, 1, 4'd4, 8'd5, 16'd7, 8'd32, 16'd255);
    send(1, 4'd4, 8'd5, 16'd7, 1, 8'd32, 16'd255, 4'd0, 2);
    send(1, 4'd5, 8'd5, 16'd7, 0, 0, 0, 0, 9);
    idle(2);
    // R7 range limits and boundary values
    wr(0, 1, 1, 4'd7, 8'd33, 16'd20, 8'd1, 16'd1);
    wr(0, 3, 1, 4'd7, 8'd1, 16'd256, 8'd1, 16'd1);
    wr(0, 4, 1, 4'd15, 8'd32, 16'd255, 8'd0, 16'd0);
    send(0, 0, 8'd33, 16'd20, 0, 0, 0, 0, 7);
    send(0, 0, 8'd1, 16'd256, 0, 0, 0, 0, 7);
    send(0, 0, 8'd32, 16'd255, 1, 8'd0, 16'd0, 4'd15, 7);
    idle(2);
    // R8 lowest index wins; disabling it exposes the next
    wr(0, 5, 1, 4'd1, 8'd2, 16'd2, 8'd1, 16'd1);
    wr(0, 6, 1, 4'd2, 8'd2, 16'd2, 8'd2, 16'd2);
    send(0, 0, 8'd2, 16'd2, 1, 8'd1, 16'd1, 4'd1, 8);
    idle(1);
    wr(0, 5, 0, 4'd1, 8'd2, 16'd2, 8'd1, 16'd1);
    send(0, 0, 8'd2, 16'd2, 1, 8'd2, 16'd2, 4'd2, 8);
    idle(4); chk_miss("R7");
    // R4 back-to-back mixed cells
    send(0, 0, 8'd5, 16'd7, 1, 8'd9, 16'd300, 4'd3, 4);
    send(0, 0, 8'd6, 16'd7, 0, 0, 0, 0, 4);
    send(1, 4'd4, 8'd5, 16'd7, 1, 8'd32, 16'd255, 4'd0, 4);
    send(0, 0, 8'd32, 16'd255, 1, 8'd0, 16'd0, 4'd15, 4);
    idle(2);
    // R10 write coincides with lookup
    fork
      send(0, 0, 8'd5, 16'd7, 1, 8'd9, 16'd300, 4'd3, 10);
      begin @(negedge clk); wr(0, 0, 1, 4'd6, 8'd5, 16'd7, 8'd11, 16'd400); end
    join
    send(0, 0, 8'd5, 16'd7, 1, 8'd11, 16'd400, 4'd6, 10);
    idle(4); chk_miss("R5");
    // R6 saturation
    for (int k = 0; k < 14; k++) send(1, 4'd1, 8'd5, 16'd7, 0, 0, 0, 0, 6);
    idle(4); chk_miss("R6");
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R4 words missing act=%0d exp=0", q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule